// File: doc/BRIEF.md
# Slot-Based Power-Rail Sequencer

The block orders the switch-on and switch-off of a set of power rails, general-purpose outputs and a 32 kHz clock gate. Three master timers each watch a trigger: one of two hardware enable pins or a software bit. Whenever its trigger changes level, a master timer emits eight slot events, one per slot period. The period is chosen from eight values, doubling from a 40 us base. Two period settings are stored per timer, one for suspend and one for shutdown, and a system-state input picks between them.

Each output (a "slave") follows either one master timer or a plain software enable bit. A slave bound to a timer has its own power-up slot and power-down slot. It turns on when a rising sequence reaches its up slot. When a falling sequence reaches its down slot, the timer's off-mode decides the result: sleep turns the slave off, low-power puts a regulator into low-power operation, and any other code leaves the slave as it was. A trigger change during a running sequence restarts the timer at slot 0 in the new direction.

Configuration is written through a simple address/data write port. The default parameters give four regulators, three general-purpose outputs and one clock gate, in that index order.

Top module: `pwr_seq`

## Requirements
- R1: After reset every `rail_en_o` and `rail_lpm_o` bit is 0.
- R2: Timer trigger select, master register bits [1:0]: 0 selects `hw_en_i[0]`, 1 selects `hw_en_i[1]`, 2 or 3 selects the timer's bit in the software trigger register (address 4, bit m for timer m). Other timers ignore a pin they do not select.
- R3: On a trigger level change the timer emits slot events 0 to 7. Slot k takes effect on a slave output in the (k*P+2)-th clock after the change is presented. P = BASE_CYCLES << code, with BASE_CYCLES = CLK_KHZ*BASE_US/1000.
- R4: The period code is master bits [4:2] when `sys_state_i` is 0 (suspend) and bits [7:5] when it is 1 (shutdown).
- R5: A slave whose source field (slave register bits [1:0]) is 3 drives its enable from slave bit [2] one clock after the write, with low-power cleared.
- R6: A slave whose source field is m (0 to 2) turns on, with low-power cleared, at rising-sequence slot equal to slave bits [5:3].
- R7: With off-mode (master bits [9:8]) equal to 1, the slave turns off at the falling-sequence slot equal to slave bits [8:6].
- R8: With off-mode 2, a regulator slave (index below N_REG) keeps its enable and sets low-power at its down slot. A non-regulator slave turns off there.
- R9: With off-mode 0 or 3, a falling sequence leaves the slave's outputs unchanged.
- R10: A trigger change while a sequence is running restarts the timer at slot 0 in the new direction. Slots of the abandoned sequence never take effect.
- R11: A slave changes only on events of its own selected timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_en_i | input | 2 | Hardware enable pins |
| sys_state_i | input | 1 | 0 suspend periods, 1 shutdown periods |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Register address: 0-2 timers, 4 software triggers, 16+s slave s |
| cfg_wdata_i | input | 16 | Write data |
| rail_en_o | output | N_REG+N_GPIO+1 | Slave enables |
| rail_lpm_o | output | N_REG+N_GPIO+1 | Slave low-power flags |

## Verification
A timer that is wrong in slot count or period moves the enable edge of a bound slave by whole periods. Sampling one clock before and one clock after the computed slot exposes it within the sequence that carries the fault. A wrong off-mode decode or direction latch shows at the down slot as a wrong pair of enable and low-power values. A missed restart leaves an abandoned slot acting, and a rail turns off several periods after a re-raise that should have kept it on. Cross-coupled timer selection shows as a slave moving on a foreign pin.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam logic [1:0] TSRC_PIN0 = 2'd0;
  localparam logic [1:0] TSRC_PIN1 = 2'd1;
  localparam logic [1:0] SSRC_SW   = 2'd3;
  localparam logic [1:0] OFF_SLEEP = 2'd1;
  localparam logic [1:0] OFF_LOWPW = 2'd2;

  typedef struct packed {
    logic [1:0] off_mode;
    logic [2:0] per_shut;
    logic [2:0] per_susp;
    logic [1:0] src;
  } mcfg_t;

  typedef struct packed {
    logic [2:0] dn_slot;
    logic [2:0] up_slot;
    logic       sw_en;
    logic [1:0] src;
  } scfg_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int BASE_CYCLES = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [2:0] per_code_i,
  output logic       evt_o,
  output logic       dir_o,
  output logic [2:0] slot_o
);
  localparam int CW = $clog2(BASE_CYCLES * 128 + 1);

  logic          trig_q, run_q, dir_q, evt_q;
  logic [2:0]    slot_q;
  logic [CW-1:0] cnt_q, last_w;
  logic          edge_w;

  assign edge_w = trig_i ^ trig_q;
  assign last_w = (CW'(BASE_CYCLES) << per_code_i) - CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q <= 1'b0;
      run_q  <= 1'b0;
      dir_q  <= 1'b0;
      evt_q  <= 1'b0;
      slot_q <= '0;
      cnt_q  <= '0;
    end else begin
      trig_q <= trig_i;
      evt_q  <= 1'b0;
      if (edge_w) begin
        dir_q  <= trig_i;
        run_q  <= 1'b1;
        slot_q <= '0;
        cnt_q  <= '0;
        evt_q  <= 1'b1;
      end else if (run_q) begin
        if (cnt_q >= last_w) begin
          cnt_q <= '0;
          if (slot_q == 3'd7) begin
            run_q <= 1'b0;
          end else begin
            slot_q <= slot_q + 3'd1;
            evt_q  <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign evt_o  = evt_q;
  assign dir_o  = dir_q;
  assign slot_o = slot_q;

  AST_EDGE_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> (evt_o && slot_o == 3'd0 && dir_o == $past(trig_i))); // R10
  AST_EVT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !edge_w) |=> !evt_o); // R3
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_w |=> $stable(dir_o)); // R10
endmodule

// File: rtl/pwr_seq_slave.sv
module pwr_seq_slave
  import pwr_seq_pkg::*;
#(
  parameter int NM     = 3,
  parameter bit IS_REG = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  scfg_t                cfg_i,
  input  logic [NM-1:0]        evt_i,
  input  logic [NM-1:0]        dir_i,
  input  logic [NM-1:0][2:0]   slot_i,
  input  logic [NM-1:0][1:0]   mode_i,
  output logic                 en_o,
  output logic                 lpm_o
);
  logic       hit, dir_w;
  logic [2:0] slot_w;
  logic [1:0] mode_w;
  logic       en_q, lpm_q;

  always_comb begin
    hit    = 1'b0;
    dir_w  = 1'b0;
    slot_w = '0;
    mode_w = '0;
    for (int k = 0; k < NM; k++) begin
      if (cfg_i.src == 2'(k)) begin
        hit    = evt_i[k];
        dir_w  = dir_i[k];
        slot_w = slot_i[k];
        mode_w = mode_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      lpm_q <= 1'b0;
    end else if (cfg_i.src == SSRC_SW) begin
      en_q  <= cfg_i.sw_en;
      lpm_q <= 1'b0;
    end else if (hit) begin
      if (dir_w) begin
        if (slot_w == cfg_i.up_slot) begin
          en_q  <= 1'b1;
          lpm_q <= 1'b0;
        end
      end else if (slot_w == cfg_i.dn_slot) begin
        case (mode_w)
          OFF_SLEEP: begin
            en_q  <= 1'b0;
            lpm_q <= 1'b0;
          end
          OFF_LOWPW: begin
            if (IS_REG) begin
              lpm_q <= 1'b1;
            end else begin
              en_q  <= 1'b0;
              lpm_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign en_o  = en_q;
  assign lpm_o = lpm_q;

  AST_SW_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src == SSRC_SW) |=> (en_o == $past(cfg_i.sw_en) && !lpm_o)); // R5
  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src != SSRC_SW && !hit) |=> ($stable(en_o) && $stable(lpm_o))); // R11
  AST_UP_CLEARS_LPM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.src != SSRC_SW && hit && dir_w && slot_w == cfg_i.up_slot) |=> (en_o && !lpm_o)); // R6
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ  = 50000,
  parameter int BASE_US  = 40,
  parameter int N_MASTER = 3,
  parameter int N_REG    = 4,
  parameter int N_GPIO   = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    hw_en_i,
  input  logic                          sys_state_i,
  input  logic                          cfg_we_i,
  input  logic [4:0]                    cfg_addr_i,
  input  logic [15:0]                   cfg_wdata_i,
  output logic [N_REG+N_GPIO:0]         rail_en_o,
  output logic [N_REG+N_GPIO:0]         rail_lpm_o
);
  localparam int NS          = N_REG + N_GPIO + 1;
  localparam int BASE_CYCLES = CLK_KHZ * BASE_US / 1000;
  localparam int MW          = $bits(mcfg_t);
  localparam int SW          = $bits(scfg_t);
  localparam logic [4:0] TRIG_ADDR  = 5'd4;
  localparam logic [4:0] SLAVE_BASE = 5'd16;

  mcfg_t [N_MASTER-1:0]       mcfg_q;
  scfg_t [NS-1:0]             scfg_q;
  logic  [N_MASTER-1:0]       sw_trig_q;
  logic  [N_MASTER-1:0]       trig_w, evt_w, dir_w;
  logic  [N_MASTER-1:0][2:0]  slot_w, per_w;
  logic  [N_MASTER-1:0][1:0]  mode_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcfg_q    <= '0;
      scfg_q    <= '0;
      sw_trig_q <= '0;
    end else if (cfg_we_i) begin
      for (int m = 0; m < N_MASTER; m++)
        if (cfg_addr_i == 5'(m)) mcfg_q[m] <= mcfg_t'(cfg_wdata_i[MW-1:0]);
      if (cfg_addr_i == TRIG_ADDR) sw_trig_q <= cfg_wdata_i[N_MASTER-1:0];
      for (int s = 0; s < NS; s++)
        if (cfg_addr_i == SLAVE_BASE + 5'(s)) scfg_q[s] <= scfg_t'(cfg_wdata_i[SW-1:0]);
    end
  end

  for (genvar m = 0; m < N_MASTER; m++) begin : g_tmr
    always_comb begin
      case (mcfg_q[m].src)
        TSRC_PIN0: trig_w[m] = hw_en_i[0];
        TSRC_PIN1: trig_w[m] = hw_en_i[1];
        default:   trig_w[m] = sw_trig_q[m];
      endcase
    end
    assign per_w[m]  = sys_state_i ? mcfg_q[m].per_shut : mcfg_q[m].per_susp;
    assign mode_w[m] = mcfg_q[m].off_mode;

    pwr_seq_timer #(.BASE_CYCLES(BASE_CYCLES)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .trig_i     (trig_w[m]),
      .per_code_i (per_w[m]),
      .evt_o      (evt_w[m]),
      .dir_o      (dir_w[m]),
      .slot_o     (slot_w[m])
    );
  end

  for (genvar s = 0; s < NS; s++) begin : g_slv
    pwr_seq_slave #(.NM(N_MASTER), .IS_REG(s < N_REG)) u_slave (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (scfg_q[s]),
      .evt_i  (evt_w),
      .dir_i  (dir_w),
      .slot_i (slot_w),
      .mode_i (mode_w),
      .en_o   (rail_en_o[s]),
      .lpm_o  (rail_lpm_o[s])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rail_en_o == '0 && rail_lpm_o == '0)); // R1
endmodule

// File: tb/pwr_seq_bench.sv
`timescale 1ns/1ps
module pwr_seq_bench;
  localparam int NS  = 8;
  localparam int BAS = 4;   // CLK_KHZ=100, BASE_US=40

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  hw_en = '0;
  logic        sys_state = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [NS-1:0] en, lpm;
  logic [2:0]  trig_sh = '0;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_seq #(.CLK_KHZ(100), .BASE_US(40)) u_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .hw_en_i(hw_en), .sys_state_i(sys_state),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .rail_en_o(en), .rail_lpm_o(lpm)
  );

  function automatic logic [15:0] mword(int src, int susp, int shut, int mode);
    return 16'((mode << 8) | (shut << 5) | (susp << 2) | src);
  endfunction
  function automatic logic [15:0] sword(int src, int sw, int up, int dn);
    return 16'((dn << 6) | (up << 3) | (sw << 2) | src);
  endfunction
  function automatic int per(int code);
    return BAS << code;
  endfunction
  // expected {en,lpm} after a falling sequence reaches the down slot, slave on before
  function automatic logic [1:0] exp_down(int mode, bit is_reg);
    if (mode == 1) return 2'b00;
    if (mode == 2) return is_reg ? 2'b11 : 2'b00;
    return 2'b10;
  endfunction

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask
  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask
  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_trig(int m, bit v);
    trig_sh[m] = v;
    wr(5'd4, {13'd0, trig_sh});
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0f17));
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    chk("R1 en", {1'b0, |en}, 2'b00);
    chk("R1 lpm", {1'b0, |lpm}, 2'b00);

    // R5: software-sourced slave
    wr(5'd19, sword(3, 1, 0, 0));
    waitn(1);
    chk("R5 sw on", {en[3], lpm[3]}, 2'b10);
    wr(5'd19, sword(3, 0, 0, 0));
    waitn(1);
    chk("R5 sw off", {en[3], lpm[3]}, 2'b00);

    // random sequences over software triggers (R3 R6 R7 R8 R9)
    for (int it = 0; it < 14; it++) begin
      int m, s, up, dn, code, mode, p;
      logic [1:0] e;
      m = $urandom % 3; s = $urandom % NS; up = $urandom % 8; dn = $urandom % 8;
      code = $urandom % 3; mode = $urandom % 4;
      if (it == 0) begin up = 7; dn = 0; mode = 2; s = 1; end
      if (it == 1) begin up = 0; dn = 7; mode = 2; s = 6; end
      p = per(code);
      wr(5'(16 + s), sword(3, 0, 0, 0));
      wr(5'(m), mword(2, code, 7, mode));
      wr(5'(16 + s), sword(m, 0, up, dn));
      set_trig(m, 1'b1);
      waitn(1 + up * p);
      chk("R3 before up slot", {en[s], lpm[s]}, 2'b00);
      waitn(1);
      chk("R6 at up slot", {en[s], lpm[s]}, 2'b10);
      waitn(8 * p);
      set_trig(m, 1'b0);
      waitn(1 + dn * p);
      chk("R3 before down slot", {en[s], lpm[s]}, 2'b10);
      waitn(1);
      e = exp_down(mode, s < 4);
      if (mode == 1) chk("R7 sleep", {en[s], lpm[s]}, e);
      else if (mode == 2) chk("R8 low power", {en[s], lpm[s]}, e);
      else chk("R9 hold", {en[s], lpm[s]}, e);
      waitn(8 * p);
    end

    // R2 R4 R11: pin triggers, shutdown vs suspend periods
    wr(5'd21, sword(3, 0, 0, 0));
    wr(5'd22, sword(3, 0, 0, 0));
    wr(5'd1, mword(0, 0, 2, 1));
    wr(5'd2, mword(1, 0, 0, 1));
    wr(5'd21, sword(1, 0, 3, 6));
    wr(5'd22, sword(2, 0, 0, 0));
    sys_state = 1'b1;
    @(negedge clk); hw_en[0] = 1'b1;
    waitn(1 + 3 * 16);
    chk("R4 shutdown period before", {en[5], lpm[5]}, 2'b00);
    waitn(1);
    chk("R2 pin0 up", {en[5], lpm[5]}, 2'b10);
    waitn(8 * 16);
    chk("R11 other timer idle", {en[6], lpm[6]}, 2'b00);
    sys_state = 1'b0;
    @(negedge clk); hw_en[0] = 1'b0;
    waitn(1 + 6 * 4);
    chk("R4 suspend period before", {en[5], lpm[5]}, 2'b10);
    waitn(1);
    chk("R4 suspend period down", {en[5], lpm[5]}, 2'b00);
    waitn(8 * 4);
    @(negedge clk); hw_en[1] = 1'b1;
    waitn(1);
    chk("R2 pin1 before", {en[6], lpm[6]}, 2'b00);
    waitn(1);
    chk("R2 pin1 up", {en[6], lpm[6]}, 2'b10);
    chk("R11 pin1 ignored by timer1", {en[5], lpm[5]}, 2'b00);
    waitn(8 * 4);

    // R10: re-raise during a falling sequence
    wr(5'd16, sword(3, 0, 0, 0));
    wr(5'd0, mword(2, 1, 1, 1));
    wr(5'd16, sword(0, 0, 1, 5));
    set_trig(0, 1'b1);
    waitn(8 * 8 + 4);
    chk("R6 restart setup", {en[0], lpm[0]}, 2'b10);
    set_trig(0, 1'b0);
    waitn(2 * 8);
    set_trig(0, 1'b1);
    waitn(30);
    chk("R10 abandoned down slot", {en[0], lpm[0]}, 2'b10);
    waitn(8 * 8);
    chk("R10 after restart", {en[0], lpm[0]}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule